// File: doc/BRIEF.md
# Fully-Associative Translation Cache with Access Status

This block caches recent virtual-to-physical page mappings so that most memory references avoid a page-table walk. A lookup presents a virtual page number and an access kind. Every stored entry is compared against it at once, and in that same cycle the block reports a hit with the physical page number, or a miss that tells the walker to start. Any mapping may live in any entry.

On a hit, the block records use of the entry on the next clock edge. The referenced flag is always set. The modified flag is set only when the access is a write that the entry's permissions allow. A hit whose access kind the entry does not permit raises a protection fault. When a walk returns, a fill request installs the mapping. The fill goes to an entry that already holds the same page if there is one, otherwise to the lowest free entry, and otherwise to an entry picked by a rotating pointer. A flush input invalidates the whole cache in one edge.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, so a lookup of any page number, including zero, reports a miss.
- R2: Lookup is combinational. With `lk_valid` high, `lk_hit` goes high and `lk_ppn` carries the stored physical page when a valid entry holds `lk_vpn`; otherwise `lk_miss` goes high. Both flags stay low while `lk_valid` is low.
- R3: `lk_ref` shows the hit entry's stored referenced flag. Any hit sets that flag at the next clock edge.
- R4: `lk_mod` shows the hit entry's stored modified flag. A hit with access kind write (`lk_acc` = 1) that is permitted sets that flag at the next edge.
- R5: Access kinds are read = 0, write = 1, execute = 2, and 3 is reserved. Permission bits are bit 0 read, bit 1 write and bit 2 execute. `lk_fault` is high on a hit whose kind has a clear permission bit, and always for kind 3. A faulted write leaves the modified flag clear.
- R6: A fill with no matching entry writes the lowest-numbered invalid entry. `fl_slot` shows the chosen index in the cycle of the request. The new entry starts with its referenced and modified flags cleared.
- R7: When every entry is valid, a fill without a match evicts the entry named by a rotating pointer. The pointer is 0 after reset, advances by one with wraparound on each eviction, and holds otherwise.
- R8: A fill whose page number matches a valid entry overwrites that entry (`fl_slot` = its index), so no page is ever held twice.
- R9: `flush` invalidates all entries at the next edge. A lookup in the same cycle reports a miss, and a fill in the same cycle is discarded.
- R10: A filled mapping hits from the cycle after the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_acc | input | 2 | Access kind (read 0, write 1, execute 2, reserved 3) |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent, walk needed |
| lk_ppn | output | PPN_W | Physical page number of the hit entry |
| lk_fault | output | 1 | Hit with disallowed access kind |
| lk_ref | output | 1 | Stored referenced flag of the hit entry |
| lk_mod | output | 1 | Stored modified flag of the hit entry |
| fl_valid | input | 1 | Install a mapping |
| fl_vpn | input | VPN_W | Virtual page of the new mapping |
| fl_ppn | input | PPN_W | Physical page of the new mapping |
| fl_perm | input | 3 | Permissions of the new mapping (bit 0 read, bit 1 write, bit 2 execute) |
| fl_slot | output | IDX_W | Entry the fill will use |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with ENTRIES = 8 and the default 20-bit virtual and 16-bit physical page widths. The small entry count lets a few fills reach a full cache. The bench can then watch the rotating pointer evict entries 0, 1 and 2 in order, and see the lowest-free choice come back after a flush. The wide page fields leave room for distinct physical values, so a stale mapping cannot be taken for a fresh overwrite.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  localparam int PERM_W = 3;

  function automatic logic perm_allows(input logic [PERM_W-1:0] perm, input logic [1:0] acc);
    case (acc)
      ACC_RD:  perm_allows = perm[0];
      ACC_WR:  perm_allows = perm[1];
      ACC_EX:  perm_allows = perm[2];
      default: perm_allows = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20
) (
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_tab,
  input  logic [VPN_W-1:0]              key,
  output logic [ENTRIES-1:0]            match
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (vpn_tab[g] == key);
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] vld,
  input  logic [ENTRIES-1:0] dup_match,
  input  logic               fill_go,
  output logic [IDX_W-1:0]   slot
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] dup_idx;
  logic             have_free;
  logic             have_dup;
  logic             evict;

  always_comb begin
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_idx  = IDX_W'(i);
        have_free = 1'b1;
      end
    end
  end

  always_comb begin
    dup_idx  = '0;
    have_dup = |dup_match;
    for (int i = 0; i < ENTRIES; i++) begin
      if (dup_match[i]) dup_idx = dup_idx | IDX_W'(i);
    end
  end

  assign evict = !have_dup && !have_free;
  assign slot  = have_dup ? dup_idx : (have_free ? free_idx : rr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fill_go && evict) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          fill_go,
  input  logic [IDX_W-1:0]              fill_slot,
  input  logic [VPN_W-1:0]              fill_vpn,
  input  logic [PPN_W-1:0]              fill_ppn,
  input  logic [tlb_pkg::PERM_W-1:0]    fill_perm,
  input  logic [ENTRIES-1:0]            hit_vec,
  input  logic                          set_mod,
  output logic [ENTRIES-1:0]            vld,
  output logic [ENTRIES-1:0][VPN_W-1:0] vpn_tab,
  output logic [ENTRIES-1:0][PPN_W-1:0] ppn_tab,
  output logic [ENTRIES-1:0][tlb_pkg::PERM_W-1:0] perm_tab,
  output logic [ENTRIES-1:0]            refd,
  output logic [ENTRIES-1:0]            mod
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic wr_here;
    assign wr_here = fill_go && (fill_slot == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        vld[g] <= 1'b0;
      end else if (wr_here) begin
        vld[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        vpn_tab[g]  <= fill_vpn;
        ppn_tab[g]  <= fill_ppn;
        perm_tab[g] <= fill_perm;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        refd[g] <= 1'b0;
        mod[g]  <= 1'b0;
      end else if (wr_here) begin
        refd[g] <= 1'b0;
        mod[g]  <= 1'b0;
      end else if (hit_vec[g]) begin
        refd[g] <= 1'b1;
        if (set_mod) mod[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [1:0]       lk_acc,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_fault,
  output logic             lk_ref,
  output logic             lk_mod,
  input  logic             fl_valid,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [PPN_W-1:0] fl_ppn,
  input  logic [2:0]       fl_perm,
  output logic [IDX_W-1:0] fl_slot,
  input  logic             flush
);

  import tlb_pkg::*;

  logic [ENTRIES-1:0]              vld;
  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_tab;
  logic [ENTRIES-1:0][PPN_W-1:0]   ppn_tab;
  logic [ENTRIES-1:0][PERM_W-1:0]  perm_tab;
  logic [ENTRIES-1:0]              refd;
  logic [ENTRIES-1:0]              mod;
  logic [ENTRIES-1:0]              lk_match;
  logic [ENTRIES-1:0]              fl_match;
  logic [ENTRIES-1:0]              hit_vec;
  logic [PERM_W-1:0]               sel_perm;
  logic                            fill_go;
  logic                            set_mod;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_cmp (
    .vld(vld), .vpn_tab(vpn_tab), .key(lk_vpn), .match(lk_match)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fl_cmp (
    .vld(vld), .vpn_tab(vpn_tab), .key(fl_vpn), .match(fl_match)
  );

  assign fill_go = fl_valid && !flush;

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .vld(vld), .dup_match(fl_match),
    .fill_go(fill_go), .slot(fl_slot)
  );

  assign lk_hit   = lk_valid && !flush && (|lk_match);
  assign lk_miss  = lk_valid && !lk_hit;
  assign hit_vec  = lk_hit ? lk_match : '0;

  always_comb begin
    lk_ppn   = '0;
    sel_perm = '0;
    lk_ref   = 1'b0;
    lk_mod   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        lk_ppn   = lk_ppn | ppn_tab[i];
        sel_perm = sel_perm | perm_tab[i];
        lk_ref   = lk_ref | refd[i];
        lk_mod   = lk_mod | mod[i];
      end
    end
  end

  assign lk_fault = lk_hit && !perm_allows(sel_perm, lk_acc);
  assign set_mod  = lk_hit && !lk_fault && (lk_acc == ACC_WR);

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .fill_go(fill_go),
    .fill_slot(fl_slot), .fill_vpn(fl_vpn), .fill_ppn(fl_ppn), .fill_perm(fl_perm),
    .hit_vec(hit_vec), .set_mod(set_mod),
    .vld(vld), .vpn_tab(vpn_tab), .ppn_tab(ppn_tab), .perm_tab(perm_tab),
    .refd(refd), .mod(mod)
  );

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_valid,
  input logic [VPN_W-1:0]   lk_vpn,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic [PPN_W-1:0]   lk_ppn,
  input logic               lk_fault,
  input logic               fl_valid,
  input logic [VPN_W-1:0]   fl_vpn,
  input logic [PPN_W-1:0]   fl_ppn,
  input logic               flush,
  input logic [ENTRIES-1:0] lk_match
);

  p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_miss));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (!lk_hit && !lk_miss));

  p_fault_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> lk_hit);

  p_no_duplicate_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  p_flush_same_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    (flush && lk_valid) |-> lk_miss);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit);

  p_fill_visible_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fl_valid && !flush) && lk_valid && !flush && lk_vpn == $past(fl_vpn))
      |-> (lk_hit && lk_ppn == $past(fl_ppn)));

endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb_fa_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
  .lk_miss(lk_miss), .lk_ppn(lk_ppn), .lk_fault(lk_fault), .fl_valid(fl_valid),
  .fl_vpn(fl_vpn), .fl_ppn(fl_ppn), .flush(flush), .lk_match(lk_match)
);

// File: tb/test_tlb_fa.sv
`timescale 1ns/1ps
module test_tlb_fa;

  localparam int ENTRIES = 8;
  localparam int VPN_W   = 20;
  localparam int PPN_W   = 16;
  localparam int IDX_W   = $clog2(ENTRIES);

  typedef struct packed {
    logic [1:0]       op;     // 0 lookup, 1 fill
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic [2:0]       aux;    // access kind or permissions
    logic             e_hit;
    logic             e_fault;
    logic [PPN_W-1:0] e_ppn;
    logic             e_ref;
    logic             e_mod;
    logic [IDX_W-1:0] e_slot;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 20'h10, 16'hA0, 3'b011, 1'b0, 1'b0, 16'h0,  1'b0, 1'b0, 3'd0}, // R6
    '{2'd1, 20'h11, 16'hA1, 3'b001, 1'b0, 1'b0, 16'h0,  1'b0, 1'b0, 3'd1}, // R6
    '{2'd0, 20'h10, 16'h0,  3'd0,   1'b1, 1'b0, 16'hA0, 1'b0, 1'b0, 3'd0}, // R2 R10
    '{2'd0, 20'h10, 16'h0,  3'd1,   1'b1, 1'b0, 16'hA0, 1'b1, 1'b0, 3'd0}, // R3
    '{2'd0, 20'h10, 16'h0,  3'd0,   1'b1, 1'b0, 16'hA0, 1'b1, 1'b1, 3'd0}, // R4
    '{2'd0, 20'h11, 16'h0,  3'd1,   1'b1, 1'b1, 16'hA1, 1'b0, 1'b0, 3'd0}, // R5
    '{2'd0, 20'h11, 16'h0,  3'd0,   1'b1, 1'b0, 16'hA1, 1'b1, 1'b0, 3'd0}, // R5
    '{2'd0, 20'h12, 16'h0,  3'd0,   1'b0, 1'b0, 16'h0,  1'b0, 1'b0, 3'd0}, // R2
    '{2'd0, 20'h11, 16'h0,  3'd2,   1'b1, 1'b1, 16'hA1, 1'b1, 1'b0, 3'd0}, // R5
    '{2'd1, 20'h11, 16'hB1, 3'b111, 1'b0, 1'b0, 16'h0,  1'b0, 1'b0, 3'd1}, // R8
    '{2'd0, 20'h11, 16'h0,  3'd2,   1'b1, 1'b0, 16'hB1, 1'b0, 1'b0, 3'd0}  // R8 R10
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             lk_valid;
  logic [VPN_W-1:0] lk_vpn;
  logic [1:0]       lk_acc;
  logic             lk_hit, lk_miss, lk_fault, lk_ref, lk_mod;
  logic [PPN_W-1:0] lk_ppn;
  logic             fl_valid;
  logic [VPN_W-1:0] fl_vpn;
  logic [PPN_W-1:0] fl_ppn;
  logic [2:0]       fl_perm;
  logic [IDX_W-1:0] fl_slot;
  logic             flush;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tlb_fa #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_tlb_fa (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn), .lk_fault(lk_fault),
    .lk_ref(lk_ref), .lk_mod(lk_mod), .fl_valid(fl_valid), .fl_vpn(fl_vpn),
    .fl_ppn(fl_ppn), .fl_perm(fl_perm), .fl_slot(fl_slot), .flush(flush)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic lv, input logic [VPN_W-1:0] lvpn, input logic [1:0] acc,
                       input logic fv, input logic [VPN_W-1:0] fvpn, input logic [PPN_W-1:0] fppn,
                       input logic [2:0] perm, input logic fl);
    @(negedge clk);
    lk_valid = lv; lk_vpn = lvpn; lk_acc = acc;
    fl_valid = fv; fl_vpn = fvpn; fl_ppn = fppn; fl_perm = perm;
    flush = fl;
    #1;
  endtask

  task automatic look(input string req, input logic [VPN_W-1:0] vpn, input logic [1:0] acc,
                      input logic e_hit, input logic e_fault, input logic [PPN_W-1:0] e_ppn,
                      input logic e_ref, input logic e_mod);
    drive(1'b1, vpn, acc, 1'b0, '0, '0, '0, 1'b0);
    chk(req, "hit", 32'(lk_hit), 32'(e_hit));
    chk(req, "miss", 32'(lk_miss), 32'(!e_hit));
    chk(req, "fault", 32'(lk_fault), 32'(e_fault));
    if (e_hit) begin
      chk(req, "ppn", 32'(lk_ppn), 32'(e_ppn));
      chk(req, "ref", 32'(lk_ref), 32'(e_ref));
      chk(req, "mod", 32'(lk_mod), 32'(e_mod));
    end
  endtask

  task automatic fill(input string req, input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                      input logic [2:0] perm, input logic [IDX_W-1:0] e_slot);
    drive(1'b0, '0, '0, 1'b1, vpn, ppn, perm, 1'b0);
    chk(req, "slot", 32'(fl_slot), 32'(e_slot));
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    lk_valid = 0; lk_vpn = '0; lk_acc = '0;
    fl_valid = 0; fl_vpn = '0; fl_ppn = '0; fl_perm = '0; flush = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: empty after reset, page zero misses
    look("R1", 20'h0, 2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    // R2: idle lookup raises neither flag
    drive(1'b0, 20'h0, 2'd0, 1'b0, '0, '0, '0, 1'b0);
    chk("R2", "idle hit", 32'(lk_hit), 32'd0);
    chk("R2", "idle miss", 32'(lk_miss), 32'd0);

    for (int v = 0; v < NV; v++) begin
      if (TBL[v].op == 2'd1)
        fill($sformatf("R6/R8 vec%0d", v), TBL[v].vpn, TBL[v].ppn, TBL[v].aux, TBL[v].e_slot);
      else
        look($sformatf("R2-vec%0d", v), TBL[v].vpn, TBL[v].aux[1:0], TBL[v].e_hit,
             TBL[v].e_fault, TBL[v].e_ppn, TBL[v].e_ref, TBL[v].e_mod);
    end

    // R6: fill remaining free entries in ascending order
    for (int k = 0; k < 6; k++)
      fill("R6", 20'h20 + 20'(k), 16'hC0 + 16'(k), 3'b001, 3'(k + 2));

    // R7: full cache, rotating pointer evicts 0, 1, 2
    fill("R7", 20'h30, 16'hD0, 3'b001, 3'd0);
    fill("R7", 20'h31, 16'hD1, 3'b001, 3'd1);
    fill("R7", 20'h32, 16'hD2, 3'b001, 3'd2);
    look("R7", 20'h10, 2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    look("R7", 20'h30, 2'd0, 1'b1, 1'b0, 16'hD0, 1'b0, 1'b0);
    look("R2", 20'h23, 2'd0, 1'b1, 1'b0, 16'hC3, 1'b0, 1'b0);
    // R5: reserved access kind always faults
    look("R5", 20'h23, 2'd3, 1'b1, 1'b1, 16'hC3, 1'b1, 1'b0);

    // R9: flush with lookup and fill in the same cycle
    drive(1'b1, 20'h30, 2'd0, 1'b1, 20'h40, 16'hE0, 3'b111, 1'b1);
    chk("R9", "flush hit", 32'(lk_hit), 32'd0);
    chk("R9", "flush miss", 32'(lk_miss), 32'd1);
    look("R9", 20'h40, 2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    look("R9", 20'h30, 2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0);

    // R6: after flush the lowest free entry is chosen again
    fill("R6", 20'h50, 16'hF0, 3'b010, 3'd0);
    look("R10", 20'h50, 2'd1, 1'b1, 1'b0, 16'hF0, 1'b0, 1'b0);
    look("R4", 20'h50, 2'd1, 1'b1, 1'b0, 16'hF0, 1'b1, 1'b1);

    drive(1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule